// File: doc/BRIEF.md
# Snooping Write-Invalidate Coherence Agent

This block is the coherence agent for one private cache on a shared-bus multiprocessor. It keeps a small direct-mapped line table and gives every line one of three states: invalid, shared (a clean copy that other caches may also hold) or modified (the only copy, and newer than memory). Processor reads and writes that hit complete in the same cycle. Any other access raises a bus request and waits for the grant. A read miss fetches the line shared. A write first gets exclusive ownership: an upgrade if the line is already held shared, or a read-exclusive if it is not held.

The agent also watches every transaction that other caches put on the bus. When another cache asks for exclusive ownership of a line held here, the local copy is dropped. When another cache reads a line held modified here, this agent drives the current data onto a supply port one cycle later, so both the requester and memory take it, and the line falls back to shared. A modified line that must leave to make room for a miss is first written back in a bus transaction of its own. Because the bus carries one transaction per cycle, all writes to one address reach every cache in the same order.

Top module: `snoop_agent`

## Requirements
- R1: After reset every line is invalid and the supply port is idle, so the first read of any address raises a bus request.
- R2: A read to a line not held raises bus_req with bus_op 1 (shared read) and bus_addr equal to cpu_addr; cpu_ready stays low until bus_gnt, and in the grant cycle cpu_ready is high and cpu_rdata equals bus_rdata; the line is then shared.
- R3: A write to a line held shared raises bus_op 3 (upgrade) and completes in its grant cycle, leaving the line modified with the written word.
- R4: A write to a line not held raises bus_op 2 (read-exclusive) and completes in its grant cycle, leaving the line modified with the written word.
- R5: A read of a shared or modified line, or a write of a modified line, completes in the same cycle with bus_req low; a read returns the stored word.
- R6: A snooped upgrade (snp_op 3) or read-exclusive (snp_op 2) whose address matches a held line makes it invalid, so the next local read of it misses.
- R7: A snooped shared read (snp_op 1) matching a modified line makes sup_valid high in the next cycle with sup_data equal to the line's word, and the line becomes shared, so a later local write needs an upgrade.
- R8: A snooped read-exclusive matching a modified line supplies its word the next cycle the same way and leaves the line invalid.
- R9: A snooped shared read of a shared line, or any snoop whose address is not held, raises no supply and leaves the line state unchanged.
- R10: A miss whose line slot holds a different modified line first raises bus_op 4 (write-back) with bus_addr the victim's address and bus_wdata its word; its grant does not complete the access, and the next request is the op for the miss.
- R11: When a snoop hits the line slot that the local request uses in the same cycle, the local request does not complete that cycle; the snoop takes effect first and the request is judged again next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_req | input | 1 | Processor access valid |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_addr | input | ADDR_W | Word address of the access |
| cpu_wdata | input | DATA_W | Write word |
| cpu_ready | output | 1 | Access completes this cycle |
| cpu_rdata | output | DATA_W | Read word, valid with cpu_ready on a read |
| bus_req | output | 1 | Request for the shared bus |
| bus_gnt | input | 1 | Bus granted to this agent this cycle |
| bus_op | output | 3 | 1 read, 2 read-exclusive, 3 upgrade, 4 write-back |
| bus_addr | output | ADDR_W | Address of the requested transaction |
| bus_wdata | output | DATA_W | Victim word during a write-back |
| bus_rdata | input | DATA_W | Line word returned in the grant cycle of a read |
| snp_valid | input | 1 | Another cache's transaction is on the bus |
| snp_op | input | 3 | Op code of the snooped transaction |
| snp_addr | input | ADDR_W | Address of the snooped transaction |
| sup_valid | output | 1 | This agent supplies a modified word |
| sup_data | output | DATA_W | Supplied word |

## Verification
A snooped transaction and a local access can target the same line slot in the same cycle. The bench provokes this with a local write to a modified line while a remote shared read of that line is on the bus. It then expects the write not to complete, the supply in the next cycle to carry the word from before the write, and the retried write to need an upgrade because the line has become shared. A write-back followed by the miss it clears, and a snoop that arrives while a local request waits for the grant, are also driven so that the op chosen at grant time reflects the newest line state.

// File: rtl/coh_pkg.sv
package coh_pkg;

    typedef enum logic [1:0] {
        LS_INV = 2'b00,
        LS_SHR = 2'b01,
        LS_MOD = 2'b10
    } line_st_e;

    typedef enum logic [2:0] {
        BOP_NONE = 3'd0,
        BOP_RD   = 3'd1,
        BOP_RDX  = 3'd2,
        BOP_UPG  = 3'd3,
        BOP_WB   = 3'd4
    } bus_op_e;

endpackage

// File: rtl/coh_line_table.sv
module coh_line_table
    import coh_pkg::*;
#(
    parameter int LINES  = 8,
    parameter int TAG_W  = 9,
    parameter int DATA_W = 32,
    localparam int IDX_W = $clog2(LINES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [IDX_W-1:0]  loc_idx,
    output line_st_e          loc_state,
    output logic [TAG_W-1:0]  loc_tag,
    output logic [DATA_W-1:0] loc_data,
    input  logic              loc_we,
    input  line_st_e          loc_state_new,
    input  logic [TAG_W-1:0]  loc_tag_new,
    input  logic [DATA_W-1:0] loc_data_new,
    input  logic [IDX_W-1:0]  snp_idx,
    output line_st_e          snp_state,
    output logic [TAG_W-1:0]  snp_tag,
    output logic [DATA_W-1:0] snp_data,
    input  logic              snp_we,
    input  line_st_e          snp_state_new
);

    line_st_e          st_d   [LINES];
    line_st_e          st_q   [LINES];
    logic [TAG_W-1:0]  tag_d  [LINES];
    logic [TAG_W-1:0]  tag_q  [LINES];
    logic [DATA_W-1:0] data_d [LINES];
    logic [DATA_W-1:0] data_q [LINES];

    assign loc_state = st_q[loc_idx];
    assign loc_tag   = tag_q[loc_idx];
    assign loc_data  = data_q[loc_idx];
    assign snp_state = st_q[snp_idx];
    assign snp_tag   = tag_q[snp_idx];
    assign snp_data  = data_q[snp_idx];

    always_comb begin
        st_d   = st_q;
        tag_d  = tag_q;
        data_d = data_q;
        if (loc_we) begin
            st_d[loc_idx]   = loc_state_new;
            tag_d[loc_idx]  = loc_tag_new;
            data_d[loc_idx] = loc_data_new;
        end
        // snoop updates win: the bus orders remote traffic first
        if (snp_we) begin
            st_d[snp_idx] = snp_state_new;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < LINES; i++) begin
                st_q[i]   <= LS_INV;
                tag_q[i]  <= '0;
                data_q[i] <= '0;
            end
        end else begin
            st_q   <= st_d;
            tag_q  <= tag_d;
            data_q <= data_d;
        end
    end

endmodule

// File: rtl/coh_snoop_dec.sv
module coh_snoop_dec
    import coh_pkg::*;
#(
    parameter int TAG_W = 9
) (
    input  logic             snp_valid,
    input  logic [2:0]       snp_op,
    input  logic [TAG_W-1:0] snp_tag,
    input  line_st_e         line_state,
    input  logic [TAG_W-1:0] line_tag,
    output logic             snp_hit,
    output logic             upd,
    output line_st_e         new_state,
    output logic             supply
);

    logic held;

    assign held = snp_valid && (line_state != LS_INV) && (line_tag == snp_tag);

    always_comb begin
        snp_hit   = 1'b0;
        upd       = 1'b0;
        new_state = line_state;
        supply    = 1'b0;
        if (held) begin
            unique case (snp_op)
                BOP_RD: begin
                    snp_hit = 1'b1;
                    if (line_state == LS_MOD) begin
                        upd       = 1'b1;
                        new_state = LS_SHR;
                        supply    = 1'b1;
                    end
                end
                BOP_RDX: begin
                    snp_hit   = 1'b1;
                    upd       = 1'b1;
                    new_state = LS_INV;
                    supply    = (line_state == LS_MOD);
                end
                BOP_UPG: begin
                    snp_hit   = 1'b1;
                    upd       = 1'b1;
                    new_state = LS_INV;
                end
                default: ;
            endcase
        end
    end

endmodule

// File: rtl/coh_req_ctl.sv
module coh_req_ctl
    import coh_pkg::*;
#(
    parameter int TAG_W  = 9,
    parameter int DATA_W = 32
) (
    input  logic              cpu_req,
    input  logic              cpu_we,
    input  logic [TAG_W-1:0]  cpu_tag,
    input  logic [DATA_W-1:0] cpu_wdata,
    input  line_st_e          line_state,
    input  logic [TAG_W-1:0]  line_tag,
    input  logic [DATA_W-1:0] line_data,
    input  logic              bus_gnt,
    input  logic [DATA_W-1:0] bus_rdata,
    input  logic              collide,
    output logic              cpu_ready,
    output logic [DATA_W-1:0] cpu_rdata,
    output logic              bus_req,
    output bus_op_e           bus_op,
    output logic              wb_sel,
    output logic              loc_we,
    output line_st_e          loc_state_new,
    output logic [TAG_W-1:0]  loc_tag_new,
    output logic [DATA_W-1:0] loc_data_new
);

    logic tag_eq;
    logic hit;

    assign tag_eq = (line_state != LS_INV) && (line_tag == cpu_tag);
    assign hit    = tag_eq && (!cpu_we || line_state == LS_MOD);

    always_comb begin
        cpu_ready     = 1'b0;
        cpu_rdata     = line_data;
        bus_req       = 1'b0;
        bus_op        = BOP_NONE;
        wb_sel        = 1'b0;
        loc_we        = 1'b0;
        loc_state_new = line_state;
        loc_tag_new   = line_tag;
        loc_data_new  = line_data;
        if (cpu_req && hit) begin
            cpu_ready = !collide;
            if (cpu_we && !collide) begin
                loc_we        = 1'b1;
                loc_state_new = LS_MOD;
                loc_data_new  = cpu_wdata;
            end
        end else if (cpu_req) begin
            bus_req = 1'b1;
            if (!tag_eq && line_state == LS_MOD) begin
                bus_op = BOP_WB;
                wb_sel = 1'b1;
            end else if (!cpu_we) begin
                bus_op = BOP_RD;
            end else if (tag_eq) begin
                bus_op = BOP_UPG;
            end else begin
                bus_op = BOP_RDX;
            end
            if (bus_gnt && !collide) begin
                loc_we = 1'b1;
                unique case (bus_op)
                    BOP_WB: begin
                        loc_state_new = LS_INV;
                    end
                    BOP_RD: begin
                        cpu_ready     = 1'b1;
                        cpu_rdata     = bus_rdata;
                        loc_state_new = LS_SHR;
                        loc_tag_new   = cpu_tag;
                        loc_data_new  = bus_rdata;
                    end
                    default: begin
                        cpu_ready     = 1'b1;
                        loc_state_new = LS_MOD;
                        loc_tag_new   = cpu_tag;
                        loc_data_new  = cpu_wdata;
                    end
                endcase
            end
        end
    end

endmodule

// File: rtl/snoop_agent.sv
module snoop_agent
    import coh_pkg::*;
#(
    parameter int ADDR_W = 12,
    parameter int DATA_W = 32,
    parameter int LINES  = 8,
    localparam int IDX_W = $clog2(LINES),
    localparam int TAG_W = ADDR_W - IDX_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cpu_req,
    input  logic              cpu_we,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic [DATA_W-1:0] cpu_wdata,
    output logic              cpu_ready,
    output logic [DATA_W-1:0] cpu_rdata,
    output logic              bus_req,
    input  logic              bus_gnt,
    output logic [2:0]        bus_op,
    output logic [ADDR_W-1:0] bus_addr,
    output logic [DATA_W-1:0] bus_wdata,
    input  logic [DATA_W-1:0] bus_rdata,
    input  logic              snp_valid,
    input  logic [2:0]        snp_op,
    input  logic [ADDR_W-1:0] snp_addr,
    output logic              sup_valid,
    output logic [DATA_W-1:0] sup_data
);

    typedef struct packed {
        logic              valid;
        logic [DATA_W-1:0] data;
    } sup_t;

    sup_t sup_d, sup_q;

    logic [IDX_W-1:0]  cpu_idx, snp_idx;
    logic [TAG_W-1:0]  cpu_tag, snp_tag;
    line_st_e          a_state, b_state, loc_state_new, snp_state_new;
    logic [TAG_W-1:0]  a_tag, b_tag, loc_tag_new;
    logic [DATA_W-1:0] a_data, b_data, loc_data_new;
    logic              loc_we, snp_we, snp_hit, snp_supply, wb_sel, collide;
    bus_op_e           op_int;

    assign cpu_idx = cpu_addr[IDX_W-1:0];
    assign cpu_tag = cpu_addr[ADDR_W-1:IDX_W];
    assign snp_idx = snp_addr[IDX_W-1:0];
    assign snp_tag = snp_addr[ADDR_W-1:IDX_W];
    assign collide = cpu_req && snp_hit && (snp_idx == cpu_idx);

    coh_line_table #(.LINES(LINES), .TAG_W(TAG_W), .DATA_W(DATA_W)) u_table (
        .clk          (clk),
        .rst_n        (rst_n),
        .loc_idx      (cpu_idx),
        .loc_state    (a_state),
        .loc_tag      (a_tag),
        .loc_data     (a_data),
        .loc_we       (loc_we),
        .loc_state_new(loc_state_new),
        .loc_tag_new  (loc_tag_new),
        .loc_data_new (loc_data_new),
        .snp_idx      (snp_idx),
        .snp_state    (b_state),
        .snp_tag      (b_tag),
        .snp_data     (b_data),
        .snp_we       (snp_we),
        .snp_state_new(snp_state_new)
    );

    coh_snoop_dec #(.TAG_W(TAG_W)) u_snoop (
        .snp_valid (snp_valid),
        .snp_op    (snp_op),
        .snp_tag   (snp_tag),
        .line_state(b_state),
        .line_tag  (b_tag),
        .snp_hit   (snp_hit),
        .upd       (snp_we),
        .new_state (snp_state_new),
        .supply    (snp_supply)
    );

    coh_req_ctl #(.TAG_W(TAG_W), .DATA_W(DATA_W)) u_req (
        .cpu_req      (cpu_req),
        .cpu_we       (cpu_we),
        .cpu_tag      (cpu_tag),
        .cpu_wdata    (cpu_wdata),
        .line_state   (a_state),
        .line_tag     (a_tag),
        .line_data    (a_data),
        .bus_gnt      (bus_gnt),
        .bus_rdata    (bus_rdata),
        .collide      (collide),
        .cpu_ready    (cpu_ready),
        .cpu_rdata    (cpu_rdata),
        .bus_req      (bus_req),
        .bus_op       (op_int),
        .wb_sel       (wb_sel),
        .loc_we       (loc_we),
        .loc_state_new(loc_state_new),
        .loc_tag_new  (loc_tag_new),
        .loc_data_new (loc_data_new)
    );

    assign bus_op    = op_int;
    assign bus_addr  = wb_sel ? {a_tag, cpu_idx} : cpu_addr;
    assign bus_wdata = wb_sel ? a_data : '0;

    always_comb begin
        sup_d.valid = snp_supply;
        sup_d.data  = snp_supply ? b_data : sup_q.data;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sup_q <= '0;
        end else begin
            sup_q <= sup_d;
        end
    end

    assign sup_valid = sup_q.valid;
    assign sup_data  = sup_q.data;

endmodule

// File: rtl/snoop_agent_chk.sv
module snoop_agent_chk #(
    parameter int ADDR_W = 12,
    parameter int IDX_W  = 3
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cpu_req,
    input logic              cpu_ready,
    input logic [ADDR_W-1:0] cpu_addr,
    input logic              bus_req,
    input logic              bus_gnt,
    input logic [2:0]        bus_op,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              snp_valid,
    input logic              sup_valid,
    input logic              collide
);

    // R2: a request that has not been granted never completes
    p_stall_r2: assert property (@(posedge clk) disable iff (!rst_n)
        bus_req && !bus_gnt |-> !cpu_ready);

    // R5: completion without a grant means no bus traffic was needed
    p_hit_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_ready && !bus_gnt |-> !bus_req);

    // R7: supply only follows a snooped transaction
    p_supply_r7: assert property (@(posedge clk) disable iff (!rst_n)
        sup_valid |-> $past(snp_valid));

    // R10: a write-back evicts the slot the current access maps to
    p_wb_slot_r10: assert property (@(posedge clk) disable iff (!rst_n)
        bus_req && bus_op == 3'd4 |-> bus_addr[IDX_W-1:0] == cpu_addr[IDX_W-1:0]);

    // R11: a same-slot snoop holds the local access back
    p_collide_r11: assert property (@(posedge clk) disable iff (!rst_n)
        collide |-> !cpu_ready);

    // R2: every request carries a real op code
    p_op_legal_r2: assert property (@(posedge clk) disable iff (!rst_n)
        bus_req |-> (bus_op != 3'd0 && bus_op <= 3'd4));

    // R1: nothing moves without a processor access
    p_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !cpu_req |-> !bus_req && !cpu_ready);

endmodule

bind snoop_agent snoop_agent_chk #(.ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .cpu_req  (cpu_req),
    .cpu_ready(cpu_ready),
    .cpu_addr (cpu_addr),
    .bus_req  (bus_req),
    .bus_gnt  (bus_gnt),
    .bus_op   (bus_op),
    .bus_addr (bus_addr),
    .snp_valid(snp_valid),
    .sup_valid(sup_valid),
    .collide  (collide)
);

// File: tb/tb_snoop_agent.sv
module tb_snoop_agent;

    localparam int AW = 12;
    localparam int DW = 32;
    localparam int NV = 36;

    typedef struct packed {
        logic [7:0]    rq;
        logic          req;
        logic          we;
        logic [AW-1:0] addr;
        logic [DW-1:0] wdata;
        logic          gnt;
        logic [DW-1:0] brd;
        logic          sv;
        logic [2:0]    sop;
        logic [AW-1:0] sa;
        logic          e_rdy;
        logic          e_req;
        logic [2:0]    e_op;
        logic          e_sup;
        logic [AW-1:0] e_baddr;
        logic [DW-1:0] e_data;
    } vec_t;

    function automatic vec_t mk(input int rq, input bit req, input bit we,
                                input int addr, input int wdata, input bit gnt,
                                input int brd, input bit sv, input int sop,
                                input int sa, input bit e_rdy, input bit e_req,
                                input int e_op, input bit e_sup, input int e_baddr,
                                input int e_data);
        vec_t v;
        v.rq = rq[7:0]; v.req = req; v.we = we; v.addr = addr[AW-1:0];
        v.wdata = wdata; v.gnt = gnt; v.brd = brd; v.sv = sv;
        v.sop = sop[2:0]; v.sa = sa[AW-1:0]; v.e_rdy = e_rdy; v.e_req = e_req;
        v.e_op = e_op[2:0]; v.e_sup = e_sup; v.e_baddr = e_baddr[AW-1:0];
        v.e_data = e_data;
        return v;
    endfunction

    // A = 0x010 (slot 0), B = 0x021 (slot 1), C = 0x018 (slot 0, other tag)
    localparam vec_t VEC [NV] = '{
        //  rq req we addr   wdata        gnt brd          sv op sa     rdy req op sup baddr  data
        mk(2, 1,0,'h010,0,           0,0,           0,0,0,     0,1,1,0,'h010,0),            // R2 stall
        mk(2, 1,0,'h010,0,           1,'h11110000,  0,0,0,     1,1,1,0,'h010,'h11110000),   // R2 fill
        mk(5, 1,0,'h010,0,           0,0,           0,0,0,     1,0,0,0,0,'h11110000),       // R5 read hit
        mk(3, 1,1,'h010,'hAAAA0001,  0,0,           0,0,0,     0,1,3,0,'h010,0),            // R3 upgrade
        mk(3, 1,1,'h010,'hAAAA0001,  1,0,           0,0,0,     1,1,3,0,'h010,0),            // R3 grant
        mk(5, 1,1,'h010,'hAAAA0002,  0,0,           0,0,0,     1,0,0,0,0,0),                // R5 write hit
        mk(7, 0,0,0,0,               0,0,           1,1,'h010, 0,0,0,0,0,0),                // R7 snoop read
        mk(7, 0,0,0,0,               0,0,           0,0,0,     0,0,0,1,0,'hAAAA0002),       // R7 supply
        mk(7, 1,1,'h010,'hAAAA0003,  0,0,           0,0,0,     0,1,3,0,'h010,0),            // R7 now shared
        mk(3, 1,1,'h010,'hAAAA0003,  1,0,           0,0,0,     1,1,3,0,'h010,0),
        mk(8, 0,0,0,0,               0,0,           1,2,'h010, 0,0,0,0,0,0),                // R8 snoop rdx
        mk(8, 0,0,0,0,               0,0,           0,0,0,     0,0,0,1,0,'hAAAA0003),       // R8 supply
        mk(8, 1,0,'h010,0,           0,0,           0,0,0,     0,1,1,0,'h010,0),            // R8 invalid
        mk(2, 1,0,'h010,0,           1,'h22220000,  0,0,0,     1,1,1,0,'h010,'h22220000),
        mk(6, 0,0,0,0,               0,0,           1,3,'h010, 0,0,0,0,0,0),                // R6 snoop upg
        mk(6, 0,0,0,0,               0,0,           0,0,0,     0,0,0,0,0,0),
        mk(6, 1,0,'h010,0,           0,0,           0,0,0,     0,1,1,0,'h010,0),            // R6 misses
        mk(2, 1,0,'h010,0,           1,'h33330000,  0,0,0,     1,1,1,0,'h010,'h33330000),
        mk(9, 0,0,0,0,               0,0,           1,1,'h010, 0,0,0,0,0,0),                // R9 read on shared
        mk(9, 0,0,0,0,               0,0,           0,0,0,     0,0,0,0,0,0),
        mk(9, 1,0,'h010,0,           0,0,           0,0,0,     1,0,0,0,0,'h33330000),       // R9 still shared
        mk(9, 0,0,0,0,               0,0,           1,2,'h021, 0,0,0,0,0,0),                // R9 not held
        mk(9, 1,0,'h010,0,           0,0,           0,0,0,     1,0,0,0,0,'h33330000),
        mk(4, 1,1,'h021,'hBBBB0001,  0,0,           0,0,0,     0,1,2,0,'h021,0),            // R4 rdx
        mk(4, 1,1,'h021,'hBBBB0001,  1,'h99999999,  0,0,0,     1,1,2,0,'h021,0),
        mk(4, 1,0,'h021,0,           0,0,           0,0,0,     1,0,0,0,0,'hBBBB0001),       // R4 holds word
        mk(3, 1,1,'h010,'hAAAA0004,  0,0,           0,0,0,     0,1,3,0,'h010,0),
        mk(3, 1,1,'h010,'hAAAA0004,  1,0,           0,0,0,     1,1,3,0,'h010,0),
        mk(10,1,0,'h018,0,           0,0,           0,0,0,     0,1,4,0,'h010,'hAAAA0004),   // R10 write-back
        mk(10,1,0,'h018,0,           1,0,           0,0,0,     0,1,4,0,'h010,'hAAAA0004),   // R10 wb grant
        mk(10,1,0,'h018,0,           0,0,           0,0,0,     0,1,1,0,'h018,0),            // R10 then read
        mk(10,1,0,'h018,0,           1,'h44440000,  0,0,0,     1,1,1,0,'h018,'h44440000),
        mk(11,1,1,'h021,'hBBBB0002,  0,0,           1,1,'h021, 0,0,0,0,0,0),                // R11 collision
        mk(11,1,1,'h021,'hBBBB0002,  0,0,           0,0,0,     0,1,3,1,'h021,'hBBBB0001),   // R11 old word
        mk(11,1,1,'h021,'hBBBB0002,  1,0,           0,0,0,     1,1,3,0,'h021,0),
        mk(11,1,0,'h021,0,           0,0,           0,0,0,     1,0,0,0,0,'hBBBB0002)
    };

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cpu_req = 1'b0, cpu_we = 1'b0, bus_gnt = 1'b0, snp_valid = 1'b0;
    logic [AW-1:0] cpu_addr = '0, snp_addr = '0;
    logic [DW-1:0] cpu_wdata = '0, bus_rdata = '0;
    logic [2:0]    snp_op = '0;
    logic          cpu_ready, bus_req, sup_valid;
    logic [DW-1:0] cpu_rdata, bus_wdata, sup_data;
    logic [2:0]    bus_op;
    logic [AW-1:0] bus_addr;

    int total = 0;
    int bad = 0;
    bit finished = 0;

    always #10 clk = ~clk;

    snoop_agent dut (
        .clk(clk), .rst_n(rst_n), .cpu_req(cpu_req), .cpu_we(cpu_we),
        .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata), .cpu_ready(cpu_ready),
        .cpu_rdata(cpu_rdata), .bus_req(bus_req), .bus_gnt(bus_gnt),
        .bus_op(bus_op), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .snp_valid(snp_valid), .snp_op(snp_op),
        .snp_addr(snp_addr), .sup_valid(sup_valid), .sup_data(sup_data)
    );

    task automatic chk(input int rq, input string what, input logic [DW-1:0] act,
                       input logic [DW-1:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL R%0d %s: actual=%0h expected=%0h", rq, what, act, exp);
        end
    endtask

    task automatic drive(input vec_t v);
        cpu_req = v.req; cpu_we = v.we; cpu_addr = v.addr; cpu_wdata = v.wdata;
        bus_gnt = v.gnt; bus_rdata = v.brd;
        snp_valid = v.sv; snp_op = v.sop; snp_addr = v.sa;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        #1;
        chk(1, "sup_valid in reset", {31'b0, sup_valid}, 0);   // R1
        chk(1, "bus_req idle", {31'b0, bus_req}, 0);
        @(negedge clk);
        rst_n = 1'b1;
        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            drive(VEC[i]);
            #1;
            chk(VEC[i].rq, $sformatf("v%0d cpu_ready", i), {31'b0, cpu_ready}, {31'b0, VEC[i].e_rdy});
            chk(VEC[i].rq, $sformatf("v%0d bus_req", i), {31'b0, bus_req}, {31'b0, VEC[i].e_req});
            chk(VEC[i].rq, $sformatf("v%0d sup_valid", i), {31'b0, sup_valid}, {31'b0, VEC[i].e_sup});
            if (VEC[i].e_req) begin
                chk(VEC[i].rq, $sformatf("v%0d bus_op", i), {29'b0, bus_op}, {29'b0, VEC[i].e_op});
                chk(VEC[i].rq, $sformatf("v%0d bus_addr", i), {20'b0, bus_addr}, {20'b0, VEC[i].e_baddr});
            end
            if (VEC[i].e_rdy && !VEC[i].we)
                chk(VEC[i].rq, $sformatf("v%0d cpu_rdata", i), cpu_rdata, VEC[i].e_data);
            if (VEC[i].e_sup)
                chk(VEC[i].rq, $sformatf("v%0d sup_data", i), sup_data, VEC[i].e_data);
            if (VEC[i].e_req && VEC[i].e_op == 3'd4)
                chk(VEC[i].rq, $sformatf("v%0d bus_wdata", i), bus_wdata, VEC[i].e_data);
        end
        // R1: reset mid-run forgets the modified line B
        @(negedge clk);
        drive('0);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        snp_valid = 1'b1; snp_op = 3'd1; snp_addr = 'h021;
        @(negedge clk);
        snp_valid = 1'b0;
        cpu_req = 1'b1; cpu_we = 1'b0; cpu_addr = 'h021;
        #1;
        chk(1, "no supply after reset", {31'b0, sup_valid}, 0);
        chk(1, "read after reset misses", {31'b0, bus_req}, 1);
        chk(1, "read op after reset", {29'b0, bus_op}, 1);
        chk(1, "not ready after reset", {31'b0, cpu_ready}, 0);
        @(negedge clk);
        drive('0);
        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL R1 watchdog: actual=running expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule